// File: doc/BRIEF.md
# Genlock Mode Controller

This block is the digital controller that decides what a reference-locked clock loop does. It works out an effective genlock enable from a register bit or an external pin, watches the incoming horizontal sync pulse for activity, and steps through four states: free run, acquisition, locked and holdover. The analog loop, its dividers and frame alignment sit outside the block. The block only drives the controls those parts need.

The sync input is resynchronised and edge-detected. A reference counts as present while detected rising edges keep arriving within a programmable number of local clock cycles. The reference is not checked for stability. Once genlock is on, any live reference is chased.

When the reference is lost, a configuration bit chooses what happens next. In free run, the loop control node is driven from a fixed bias. In holdover, the filter drive is put into high impedance so that the stored control level is kept. The controller goes back to acquisition as soon as edges return. The locked state is declared only after the loop's lock indication has held across a programmable number of consecutive sync edges. It is dropped on the first cycle that indication falls.

Top module: `genlock_ctrl`

## Requirements
- R1: The effective genlock enable is `mode_reg_i` when `mode_src_i` is 1, and `mode_pin_i` when `mode_src_i` is 0.
- R2: While the effective enable is 0, the state is free run (`state_o` = 0) one cycle later, whatever the sync input does, and `bias_sel_o` is 1.
- R3: With the effective enable at 1, a detected sync edge moves the block from free run to acquisition (`state_o` = 1).
- R4: `href_i` passes through two flip-flops and a rising-edge detector. The reference stays present while detected edges are at most `ref_timeout_i` cycles apart (`ref_timeout_i` ≥ 1). It is declared lost when a gap exceeds that value.
- R5: On loss of reference in acquisition or locked with `holdover_en_i` = 0, the state becomes free run.
- R6: On loss of reference in acquisition or locked with `holdover_en_i` = 1, the state becomes holdover (`state_o` = 3), with `lpf_hiz_o` = 1 and `bias_sel_o` = 0.
- R7: From free run or holdover with the enable at 1, a returning reference moves the state to acquisition.
- R8: Acquisition moves to locked (`state_o` = 2) once `loop_lock_i` has been high at `lock_periods_i` consecutive detected sync edges (`lock_periods_i` ≥ 1). Locked returns to acquisition on the first cycle `loop_lock_i` is low.
- R9: Outputs {`no_ref_o`,`no_lock_o`,`bias_sel_o`,`lpf_hiz_o`} per state: free run 1110, acquisition 0100, locked 0000, holdover 1101.
- R10: Reset (`rst_ni` low, asynchronous) puts the block in free run with both status flags at 1.
- R11: If loss of reference and a lock drop happen in the same cycle while locked, the loss decides the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_reg_i | input | 1 | Register genlock enable |
| mode_pin_i | input | 1 | Pin genlock enable |
| mode_src_i | input | 1 | 1 selects register enable, 0 selects pin |
| holdover_en_i | input | 1 | Loss-of-reference action: 1 holdover, 0 free run |
| href_i | input | 1 | Reference horizontal sync, asynchronous |
| loop_lock_i | input | 1 | Lock indication from the loop |
| ref_timeout_i | input | TO_W | Maximum edge gap in clock cycles |
| lock_periods_i | input | LK_W | Sync edges with lock needed to enter locked |
| no_ref_o | output | 1 | No reference in use |
| no_lock_o | output | 1 | Loop not in locked state |
| bias_sel_o | output | 1 | Route free-run bias to loop control node |
| lpf_hiz_o | output | 1 | Loop filter drive in high impedance |
| state_o | output | 2 | Current state: 0 free, 1 acquire, 2 locked, 3 holdover |

## Verification
The timeout counter and the lock-drop path can both act on the locked state in the same cycle. The bench provokes this with one hand-placed sync pulse and counts clock edges from it to the exact cycle in which the reference monitor declares loss. It pulls `loop_lock_i` low for that single cycle only. The state read one edge later must be holdover, not acquisition. Separately, edge trains spaced exactly at the timeout, and one cycle beyond it, pin down the boundary of loss detection.

// File: rtl/genlock_pkg.sv
package genlock_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2,
    ST_HOLD = 2'd3
  } gl_state_e;
endpackage

// File: rtl/gl_sync_edge.sv
module gl_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/gl_ref_monitor.sv
module gl_ref_monitor #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            ref_ok_o
);
  logic [TO_W-1:0] gap_q;
  logic            ok_q;
  logic [TO_W-1:0] gap_nx;

  assign gap_nx = gap_q + TO_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      ok_q  <= 1'b0;
    end else if (edge_i) begin
      gap_q <= '0;
      ok_q  <= 1'b1;
    end else if (ok_q) begin
      if (gap_nx >= timeout_i) begin
        ok_q  <= 1'b0;
        gap_q <= '0;
      end else begin
        gap_q <= gap_nx;
      end
    end
  end

  assign ref_ok_o = ok_q;

  a_r4_edge_sets_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> ref_ok_o);
endmodule

// File: rtl/gl_lock_qual.sv
module gl_lock_qual #(
  parameter int unsigned LK_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            lock_i,
  input  logic            edge_i,
  input  logic [LK_W-1:0] need_i,
  output logic            qual_o
);
  logic [LK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !lock_i)  cnt_q <= '0;
    else if (edge_i && !qual_o) cnt_q <= cnt_q + LK_W'(1);
  end

  assign qual_o = (cnt_q >= need_i);

  a_r8_lock_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> (!qual_o || need_i == '0));
endmodule

// File: rtl/genlock_ctrl.sv
module genlock_ctrl
  import genlock_pkg::*;
#(
  parameter int unsigned TO_W        = 16,
  parameter int unsigned LK_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_reg_i,
  input  logic            mode_pin_i,
  input  logic            mode_src_i,
  input  logic            holdover_en_i,
  input  logic            href_i,
  input  logic            loop_lock_i,
  input  logic [TO_W-1:0] ref_timeout_i,
  input  logic [LK_W-1:0] lock_periods_i,
  output logic            no_ref_o,
  output logic            no_lock_o,
  output logic            bias_sel_o,
  output logic            lpf_hiz_o,
  output logic [1:0]      state_o
);
  gl_state_e state_q, state_d, lor_tgt;
  logic      gnlk, sync_rise, ref_ok, lock_qual;

  assign gnlk    = mode_src_i ? mode_reg_i : mode_pin_i;
  assign lor_tgt = holdover_en_i ? ST_HOLD : ST_FREE;

  gl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (href_i),
    .rise_o  (sync_rise)
  );

  gl_ref_monitor #(.TO_W(TO_W)) u_refmon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (sync_rise),
    .timeout_i (ref_timeout_i),
    .ref_ok_o  (ref_ok)
  );

  gl_lock_qual #(.LK_W(LK_W)) u_lockq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_ACQ),
    .lock_i (loop_lock_i),
    .edge_i (sync_rise),
    .need_i (lock_periods_i),
    .qual_o (lock_qual)
  );

  // loss of reference outranks lock events
  always_comb begin
    state_d = state_q;
    if (!gnlk) begin
      state_d = ST_FREE;
    end else begin
      unique case (state_q)
        ST_FREE: if (ref_ok) state_d = ST_ACQ;
        ST_ACQ: begin
          if (!ref_ok)        state_d = lor_tgt;
          else if (lock_qual) state_d = ST_LOCK;
        end
        ST_LOCK: begin
          if (!ref_ok)           state_d = lor_tgt;
          else if (!loop_lock_i) state_d = ST_ACQ;
        end
        ST_HOLD: if (ref_ok) state_d = ST_ACQ;
        default: state_d = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FREE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_ACQ:  {no_ref_o, no_lock_o, bias_sel_o, lpf_hiz_o} = 4'b0100;
      ST_LOCK: {no_ref_o, no_lock_o, bias_sel_o, lpf_hiz_o} = 4'b0000;
      ST_HOLD: {no_ref_o, no_lock_o, bias_sel_o, lpf_hiz_o} = 4'b1101;
      default: {no_ref_o, no_lock_o, bias_sel_o, lpf_hiz_o} = 4'b1110;
    endcase
  end

  assign state_o = state_q;

  a_r2_off_forces_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnlk |=> state_q == ST_FREE);

  a_r5_loss_to_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnlk && !ref_ok && !holdover_en_i && (state_q == ST_ACQ || state_q == ST_LOCK))
    |=> state_q == ST_FREE);

  a_r7_hold_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnlk && ref_ok && state_q == ST_HOLD) |=> state_q == ST_ACQ);

  a_r8_lock_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnlk && ref_ok && !loop_lock_i && state_q == ST_LOCK) |=> state_q == ST_ACQ);

  a_r11_loss_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnlk && !ref_ok && holdover_en_i && state_q == ST_LOCK) |=> state_q == ST_HOLD);

  a_r10_reset_free: assert property (@(posedge clk_i)
    !rst_ni |-> (state_q == ST_FREE && no_ref_o && no_lock_o));
endmodule

// File: tb/genlock_ctrl_tb.sv
module genlock_ctrl_tb;
  localparam int unsigned TO_W = 16;
  localparam int unsigned LK_W = 8;
  localparam int PER  = 16;
  localparam int TOUT = 40;
  localparam int NVEC = 13;
  // {src, reg, pin, hold, ref_on, lock, exp_state[1:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b100011_00, 8'b110011_10, 8'b110010_01, 8'b110000_00,
    8'b110111_10, 8'b110101_11, 8'b110111_10, 8'b010111_00,
    8'b001111_10, 8'b001001_00, 8'b001110_01, 8'b001100_11,
    8'b100100_00
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_reg = 1'b0, mode_pin = 1'b0, mode_src = 1'b1, hold_en = 1'b0;
  logic loop_lock = 1'b0;
  logic gen_on = 1'b0, gen_href = 1'b0, man_href = 1'b0;
  logic href;
  logic [TO_W-1:0] tout = TO_W'(TOUT);
  logic [LK_W-1:0] nlock = LK_W'(3);
  logic no_ref, no_lock, bias_sel, lpf_hiz;
  logic [1:0] state;
  int n_chk = 0, n_bad = 0;
  logic mon_en = 1'b0, seen_noref = 1'b0;

  always #2 clk = ~clk;
  assign href = gen_href | man_href;

  genlock_ctrl #(.TO_W(TO_W), .LK_W(LK_W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_reg_i(mode_reg), .mode_pin_i(mode_pin),
    .mode_src_i(mode_src), .holdover_en_i(hold_en), .href_i(href),
    .loop_lock_i(loop_lock), .ref_timeout_i(tout), .lock_periods_i(nlock),
    .no_ref_o(no_ref), .no_lock_o(no_lock), .bias_sel_o(bias_sel),
    .lpf_hiz_o(lpf_hiz), .state_o(state)
  );

  function automatic logic [3:0] flags_of(logic [1:0] s);
    case (s)
      2'd0:    return 4'b1110;
      2'd1:    return 4'b0100;
      2'd2:    return 4'b0000;
      default: return 4'b1101;
    endcase
  endfunction

  function automatic string vec_tag(int i);
    case (i)
      0, 12:   return "R2";
      3, 9:    return "R5";
      5, 11:   return "R6";
      6, 10:   return "R7";
      4:       return "R3";
      7, 8:    return "R1";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(string req, logic [1:0] exp);
    check(req, 32'(state), 32'(exp));
    check({req, "/R9 flags"}, 32'({no_ref, no_lock, bias_sel, lpf_hiz}), 32'(flags_of(exp)));
  endtask

  task automatic pulses(int gap, int cnt);
    for (int k = 0; k < cnt; k++) begin
      man_href = 1'b1;
      @(negedge clk);
      man_href = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (gen_on) begin
        gen_href = 1'b1;
        @(negedge clk);
        gen_href = 1'b0;
        repeat (PER - 2) @(negedge clk);
      end
    end
  end

  always @(negedge clk) if (mon_en && no_ref) seen_noref <= 1'b1;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R10 in reset", 2'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_state("R10 after reset", 2'd0);

    for (int i = 0; i < NVEC; i++) begin
      {mode_src, mode_reg, mode_pin, hold_en, gen_on, loop_lock} = VEC[i][7:2];
      repeat (240) @(negedge clk);
      check_state(vec_tag(i), VEC[i][1:0]);
    end

    // R4: edge gap equal to timeout keeps reference, one more cycle loses it
    mode_reg = 1'b1; hold_en = 1'b0; loop_lock = 1'b0; tout = TO_W'(10);
    repeat (20) @(negedge clk);
    pulses(10, 4);
    seen_noref = 1'b0; mon_en = 1'b1;
    pulses(10, 8);
    mon_en = 1'b0;
    check("R4 gap at timeout keeps ref", 32'(seen_noref), 32'd0);
    check_state("R4 still acquiring", 2'd1);
    seen_noref = 1'b0; mon_en = 1'b1;
    pulses(11, 8);
    mon_en = 1'b0;
    check("R4 gap past timeout loses ref", 32'(seen_noref), 32'd1);
    repeat (40) @(negedge clk);
    check_state("R5 idle after train", 2'd0);
    tout = TO_W'(TOUT);

    // R8: qualification needs the programmed number of edges
    nlock = LK_W'(20); loop_lock = 1'b1; gen_on = 1'b1;
    repeat (200) @(negedge clk);
    check_state("R8 not yet qualified", 2'd1);
    repeat (250) @(negedge clk);
    check_state("R8 qualified", 2'd2);
    nlock = LK_W'(3);

    // R8: one-cycle lock drop leaves locked
    loop_lock = 1'b0;
    @(negedge clk);
    loop_lock = 1'b1;
    repeat (2) @(negedge clk);
    check_state("R8 first deassertion", 2'd1);
    repeat (100) @(negedge clk);
    check_state("R8 relock", 2'd2);

    // R11: loss and lock drop in the same cycle
    hold_en = 1'b1;
    gen_on = 1'b0;
    repeat (PER + 2) @(negedge clk);
    man_href = 1'b1;
    @(negedge clk);
    man_href = 1'b0;
    repeat (2 + TOUT) @(negedge clk);
    loop_lock = 1'b0;
    @(negedge clk);
    loop_lock = 1'b1;
    check_state("R11 loss outranks lock drop", 2'd3);
    repeat (10) @(negedge clk);
    check_state("R6 holdover kept", 2'd3);

    // R10: reset during operation
    gen_on = 1'b1;
    repeat (100) @(negedge clk);
    check_state("R7 back from holdover", 2'd2);
    rst_ni = 1'b0;
    #1;
    check_state("R10 async reset", 2'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    gen_on = 1'b0;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule